// File: doc/BRIEF.md
# One-Shot Pulse Timer Channel

This block is a down-counting timer channel that emits exactly one pulse each time it is started. Software first programs a 24-bit reload value. A start request then arms the channel. The request comes either from a register write that sets the run bit or from a single-cycle external start strobe. Time advances only on cycles where the count-clock enable `cnt_tick` is high. On the first such tick after arming, the counter takes the reload value and the output flip-flop inverts. Each later tick decrements the counter. The tick that finds the counter at zero is the underflow: the counter wraps, the output flip-flop inverts again, the run bit clears and, if enabled, an interrupt pulse is raised.

The resulting pulse on `pulse_out` lasts reload + 1 tick periods. Its polarity comes from an initial level that software can set while the channel is stopped. When an underflow, the external start and a software run-bit write land in the same clock, fixed priorities decide the outcome. The counter is built from a 16-bit low half and an 8-bit high half, and the high half borrows when the low half wraps.

The register port is a plain single-cycle write strobe with a combinational read mux. It has no valid/ready handshake and never applies back-pressure: every write is taken in the cycle it is presented. The block has no streaming data path.

Top module: `oneshot_timer`

## Requirements
- R1: After reset `pulse_out` and `irq` are 0, and every register (reload at address 0, control at address 1, counter at address 2, level at address 3) reads 0.
- R2: Writing control (address 1) with bit 0 = 1 arms the channel, and the run bit reads back 1. Nothing changes at the output until the next `cnt_tick`: on that tick the counter reads the reload value and `pulse_out` inverts.
- R3: Each later `cnt_tick` lowers the counter by exactly one. When the low 16 bits wrap from 0, the upper 8 bits decrement (0x010000 becomes 0x00FFFF).
- R4: `pulse_out` inverts again on the tick that finds the counter at 0, so it stays inverted for reload + 1 tick periods. That tick clears the run bit and leaves the counter at 0xFFFFFF. Further ticks change nothing.
- R5: `irq` is high for exactly one clock, the cycle after the underflow tick, and only when control bit 1 (interrupt enable) is 1. When that bit is 0, `irq` stays low.
- R6: A one-cycle `ext_start` pulse while stopped arms the channel exactly as a run-bit write does.
- R7: If an underflow and `ext_start` occur in the same clock, the channel stops: run reads 0 and later ticks change nothing.
- R8: If an underflow and a control write with bit 0 = 1 occur in the same clock, run stays 1. The next tick reloads the counter and inverts `pulse_out` to start a new pulse.
- R9: If `ext_start` and a control write with bit 0 = 0 occur in the same clock, the channel stays stopped and later ticks neither load the counter nor move `pulse_out`.
- R10: Writing the level register (address 3, bit 0) while stopped sets `pulse_out` to that bit one clock later. Such a write while running has no effect.
- R11: Writing control bit 0 = 0 during a count freezes both the counter value and `pulse_out`, whatever later ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe, taken in the cycle it is high |
| reg_addr | input | 2 | Register address for writes and reads |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Combinational read data for `reg_addr` |
| cnt_tick | input | 1 | Count-clock enable, one system clock per count period |
| ext_start | input | 1 | External start strobe |
| pulse_out | output | 1 | Output flip-flop level |
| irq | output | 1 | One-cycle underflow interrupt request |

## Verification
Every state change lands on the rising edge where its cause is sampled. The counter, the run bit and `pulse_out` therefore show the effect of a tick or a write one clock after it was driven, and `irq` follows the underflow tick by that same single clock. The bench drives all inputs on the falling edge. It samples outputs and reads registers on the next falling edge, half a period after the edge that consumed the stimulus. It then samples once more a further cycle later to confirm that `irq` has fallen. Same-cycle collisions are produced by raising both causes in one falling-edge slot, so they meet the same rising edge.

// File: rtl/oneshot_timer_pkg.sv
package oneshot_timer_pkg;
  typedef enum logic [1:0] {
    ADR_RELOAD = 2'd0,
    ADR_CTRL   = 2'd1,
    ADR_COUNT  = 2'd2,
    ADR_LEVEL  = 2'd3
  } reg_addr_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IE_BIT  = 1;
endpackage

// File: rtl/ost_split_counter.sv
module ost_split_counter #(
  parameter int LO_W = 16,
  parameter int HI_W = 8,
  localparam int CNT_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] value,
  output logic             is_zero
);
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            lo_wrap;

  assign lo_wrap = (lo_q == '0);
  assign value   = {hi_q, lo_q};
  assign is_zero = lo_wrap && (hi_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      lo_q <= reload[LO_W-1:0];
      hi_q <= reload[CNT_W-1:LO_W];
    end else if (dec) begin
      lo_q <= lo_q - 1'b1;
      if (lo_wrap) hi_q <= hi_q - 1'b1;
    end
  end

  assert_dec_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !is_zero) |=> (value == $past(value) - 1'b1));

  assert_hi_borrow_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(dec && lo_wrap)) |=> $stable(hi_q));

  assert_wrap_on_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && is_zero) |=> (value == '1));
endmodule

// File: rtl/ost_run_ctrl.sv
module ost_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ext_start,
  input  logic wr_run,
  input  logic wr_run_val,
  input  logic cnt_zero,
  output logic run,
  output logic load,
  output logic dec,
  output logic underflow
);
  logic run_q, loaded_q, stop_wr, run_d;

  assign stop_wr   = wr_run && !wr_run_val;
  assign load      = tick && run_q && !loaded_q && !stop_wr;
  assign dec       = tick && run_q && loaded_q && !stop_wr;
  assign underflow = dec && cnt_zero;
  assign run       = run_q;

  // Priority: software write, then underflow stop, then external start.
  always_comb begin
    if (wr_run)         run_d = wr_run_val;
    else if (underflow) run_d = 1'b0;
    else if (ext_start) run_d = 1'b1;
    else                run_d = run_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      loaded_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (stop_wr || underflow) loaded_q <= 1'b0;
      else if (load)            loaded_q <= 1'b1;
    end
  end

  assert_uf_beats_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && ext_start && !wr_run) |=> !run_q);

  assert_swen_beats_uf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_run && wr_run_val) |=> run_q);

  assert_swdis_beats_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_run && !wr_run_val) |=> (!run_q && !loaded_q));

  assert_load_dec_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && dec));
endmodule

// File: rtl/ost_output_stage.sv
module ost_output_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  input  logic lvl_wr,
  input  logic lvl_val,
  input  logic underflow,
  input  logic irq_en,
  output logic level,
  output logic irq
);
  logic level_q, irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (lvl_wr)      level_q <= lvl_val;
      else if (toggle) level_q <= !level_q;
      irq_q <= underflow && irq_en;
    end
  end

  assign level = level_q;
  assign irq   = irq_q;

  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!toggle && !lvl_wr) |=> $stable(level_q));

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_q);
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_timer_pkg::*;
#(
  parameter int LO_W = 16,
  parameter int HI_W = 8,
  localparam int CNT_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             cnt_tick,
  input  logic             ext_start,
  output logic             pulse_out,
  output logic             irq
);
  logic [CNT_W-1:0] reload_q, cnt_value;
  logic             ie_q, run, load, dec, underflow, cnt_zero;
  logic             wr_ctrl, lvl_wr;
  reg_addr_e        addr;

  assign addr    = reg_addr_e'(reg_addr);
  assign wr_ctrl = reg_we && (addr == ADR_CTRL);
  assign lvl_wr  = reg_we && (addr == ADR_LEVEL) && !run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      ie_q     <= 1'b0;
    end else begin
      if (reg_we && addr == ADR_RELOAD) reload_q <= reg_wdata;
      if (wr_ctrl)                      ie_q     <= reg_wdata[CTRL_IE_BIT];
    end
  end

  ost_run_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (cnt_tick),
    .ext_start  (ext_start),
    .wr_run     (wr_ctrl),
    .wr_run_val (reg_wdata[CTRL_RUN_BIT]),
    .cnt_zero   (cnt_zero),
    .run        (run),
    .load       (load),
    .dec        (dec),
    .underflow  (underflow)
  );

  ost_split_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .dec     (dec),
    .reload  (reload_q),
    .value   (cnt_value),
    .is_zero (cnt_zero)
  );

  ost_output_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .toggle    (load || underflow),
    .lvl_wr    (lvl_wr),
    .lvl_val   (reg_wdata[0]),
    .underflow (underflow),
    .irq_en    (ie_q),
    .level     (pulse_out),
    .irq       (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (addr)
      ADR_RELOAD: reg_rdata = reload_q;
      ADR_CTRL: begin
        reg_rdata[CTRL_RUN_BIT] = run;
        reg_rdata[CTRL_IE_BIT]  = ie_q;
      end
      ADR_COUNT:  reg_rdata = cnt_value;
      ADR_LEVEL:  reg_rdata[0] = pulse_out;
      default:    reg_rdata = '0;
    endcase
  end

  assert_level_wr_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && addr == ADR_LEVEL && run && !load && !underflow) |=> $stable(pulse_out));
endmodule

// File: tb/test_oneshot_timer.sv
module test_oneshot_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        cnt_tick = 1'b0;
  logic        ext_start = 1'b0;
  logic        pulse_out, irq;
  logic        irq_seen;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  oneshot_timer i_oneshot_timer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_tick(cnt_tick),
    .ext_start(ext_start), .pulse_out(pulse_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_we = 1'b0; cnt_tick = 1'b0; ext_start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [23:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tick();
    cnt_tick = 1'b1;
    @(negedge clk);
    cnt_tick = 1'b0;
    irq_seen = irq;
  endtask

  task automatic t_reset();
    logic [23:0] v;
    do_reset();
    chk("R1 pulse_out", pulse_out, 0);
    chk("R1 irq", irq, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 register", v, 0);
    end
  endtask

  task automatic t_single_pulse();
    logic [23:0] v;
    do_reset();
    wr(2'd0, 24'd3);
    wr(2'd1, 24'h3);
    rd(2'd1, v); chk("R2 run bit", v, 3);
    repeat (3) @(negedge clk);
    chk("R2 no output before tick", pulse_out, 0);
    rd(2'd2, v); chk("R2 counter before tick", v, 0);
    tick();
    chk("R2 output inverts on load", pulse_out, 1);
    rd(2'd2, v); chk("R2 counter loaded", v, 3);
    for (int i = 2; i >= 0; i--) begin
      tick();
      rd(2'd2, v); chk("R3 decrement", v, i);
      chk("R4 output held", pulse_out, 1);
      chk("R5 no early irq", irq_seen, 0);
    end
    tick();
    chk("R4 output back on underflow", pulse_out, 0);
    chk("R5 irq after underflow", irq_seen, 1);
    rd(2'd2, v); chk("R4 counter wrapped", v, 24'hFFFFFF);
    rd(2'd1, v); chk("R4 run cleared", v, 2);
    @(negedge clk);
    chk("R5 irq one cycle", irq, 0);
    repeat (2) tick();
    chk("R4 stopped output", pulse_out, 0);
    rd(2'd2, v); chk("R4 stopped counter", v, 24'hFFFFFF);
  endtask

  task automatic t_irq_masked();
    do_reset();
    wr(2'd0, 24'd0);
    wr(2'd1, 24'h1);
    tick();
    chk("R4 reload zero load", pulse_out, 1);
    tick();
    chk("R4 reload zero width", pulse_out, 0);
    chk("R5 masked irq", irq_seen, 0);
  endtask

  task automatic t_borrow_freeze();
    logic [23:0] v;
    do_reset();
    wr(2'd0, 24'h010000);
    wr(2'd1, 24'h1);
    tick();
    tick();
    rd(2'd2, v); chk("R3 borrow into high part", v, 24'h00FFFF);
    tick();
    rd(2'd2, v); chk("R3 low decrement", v, 24'h00FFFE);
    wr(2'd1, 24'h0);
    repeat (3) tick();
    rd(2'd2, v); chk("R11 frozen counter", v, 24'h00FFFE);
    chk("R11 frozen output", pulse_out, 1);
  endtask

  task automatic t_ext_start();
    logic [23:0] v;
    do_reset();
    wr(2'd0, 24'd5);
    ext_start = 1'b1;
    @(negedge clk);
    ext_start = 1'b0;
    rd(2'd1, v); chk("R6 ext arms", v, 1);
    chk("R6 no output before tick", pulse_out, 0);
    tick();
    chk("R6 output inverts", pulse_out, 1);
    rd(2'd2, v); chk("R6 counter loaded", v, 5);
  endtask

  task automatic t_uf_vs_ext();
    logic [23:0] v;
    do_reset();
    wr(2'd0, 24'd0);
    wr(2'd1, 24'h1);
    tick();
    cnt_tick = 1'b1; ext_start = 1'b1;
    @(negedge clk);
    cnt_tick = 1'b0; ext_start = 1'b0;
    rd(2'd1, v); chk("R7 stop wins", v, 0);
    chk("R7 output after underflow", pulse_out, 0);
    tick();
    chk("R7 no restart", pulse_out, 0);
    rd(2'd2, v); chk("R7 counter idle", v, 24'hFFFFFF);
  endtask

  task automatic t_uf_vs_swen();
    logic [23:0] v;
    do_reset();
    wr(2'd0, 24'd0);
    wr(2'd1, 24'h1);
    tick();
    cnt_tick = 1'b1; reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 24'h1;
    @(negedge clk);
    cnt_tick = 1'b0; reg_we = 1'b0;
    rd(2'd1, v); chk("R8 write wins", v, 1);
    chk("R8 underflow inverted", pulse_out, 0);
    tick();
    chk("R8 new pulse", pulse_out, 1);
    rd(2'd2, v); chk("R8 reloaded", v, 0);
    tick();
    chk("R8 second pulse ends", pulse_out, 0);
  endtask

  task automatic t_ext_vs_swdis();
    logic [23:0] v;
    do_reset();
    wr(2'd0, 24'd4);
    ext_start = 1'b1; reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 24'h0;
    @(negedge clk);
    ext_start = 1'b0; reg_we = 1'b0;
    rd(2'd1, v); chk("R9 disable wins", v, 0);
    repeat (2) tick();
    chk("R9 output unmoved", pulse_out, 0);
    rd(2'd2, v); chk("R9 counter not loaded", v, 0);
  endtask

  task automatic t_level();
    do_reset();
    wr(2'd3, 24'h1);
    chk("R10 level set while stopped", pulse_out, 1);
    wr(2'd0, 24'd2);
    wr(2'd1, 24'h1);
    tick();
    chk("R10 inverted from set level", pulse_out, 0);
    wr(2'd3, 24'h1);
    chk("R10 write ignored while running", pulse_out, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single_pulse();
    t_irq_masked();
    t_borrow_freeze();
    t_ext_start();
    t_uf_vs_ext();
    t_uf_vs_swen();
    t_ext_vs_swdis();
    t_level();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule